// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Model

This block is a synthesizable, scaled-down behavioural model of a one-bit-wide dynamic memory. Its array is square, with 2^ADDR_W rows and 2^ADDR_W columns. One shared address bus carries the row address and then the column address. A falling row strobe (`ras_n`) captures the row and opens it. Each later falling column strobe (`cas_n`) captures a column in that row. At that same edge the write-select line `we_n` picks the operation: low stores `din` into the cell, high drives the cell onto `dout`. `dout` stays valid until the column strobe rises again. Holding the row strobe low while the column strobe toggles streams many columns from one open row, which is fast page mode.

If the column strobe is already low when the row strobe falls, the cycle is a refresh. An internal row counter replaces the external address, the counted row is marked as refreshed, and the counter then advances. The strobes are sampled on `clk`, and an edge is a change between two consecutive samples. Analog charge decay is not modelled. The only trace of refresh is a per-row flag, seen through `all_fresh`. The defaults are kept small for simulation. Setting ADDR_W to 10 gives the full 1024 by 1024 organisation.

Top module: `mxa_dram`

## Requirements
- R1: On the clock where `ras_n` is first sampled low with `cas_n` high (or newly low), the value on `addr` is kept as the open row. On a later clock where `cas_n` is first sampled low, the value on `addr` selects the column. After those edges, changes on `addr` have no effect on the access.
- R2: A write replaces the old contents of the selected cell with `din`. A later read of that cell returns the new value.
- R3: A read (`we_n` high at the column edge) sets `dout_en` to 1 and puts the cell value on `dout` from the clock after the column edge, for as long as `cas_n` stays low. Reading does not change the stored bit.
- R4: From the clock after `cas_n` is sampled high again, `dout_en` is 0 and `dout` is 0.
- R5: While `ras_n` stays low, every new falling `cas_n` accesses a new column of the same open row, with no new row address. Data written this way is visible in that row only.
- R6: A falling `ras_n` while `cas_n` has been low since the previous sample is a refresh. On the next clock `rfsh_stb` is 1 for one cycle and `rfsh_row` shows the refreshed row. No row opens, `dout_en` stays 0, and no cell changes.
- R7: The refresh row counter starts at 0 after reset, steps by one after each refresh, and returns from the last row to row 0.
- R8: `all_fresh` is 0 after reset. It becomes 1 once every row has been refreshed at least once, and it stays 1.
- R9: A rising `ras_n` closes the row. Falling `cas_n` pulses while no row is open write nothing and drive nothing.
- R10: During and right after reset, `dout_en`, `dout`, `rfsh_stb` and `all_fresh` are 0.
- R11: `we_n` is taken at the column edge. When it is low the cell is written and `dout_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for strobes and data |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Shared row/column address bus |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write select: 0 write, 1 read |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not driven |
| dout_en | output | 1 | Read data valid (output-enable stand-in) |
| rfsh_stb | output | 1 | One-cycle pulse after a refresh |
| rfsh_row | output | ADDR_W | Row refreshed by the last refresh |
| all_fresh | output | 1 | Every row refreshed at least once |

## Verification
A table of cells is written, with each cell in its own row cycle, and then read back. The table contains pairs that swap row and column and carry opposite data, so a design that mixes up the two latches, or takes the column from the bus after the edge, returns the wrong bit. Page-mode bursts write and read four columns under one row strobe. A neighbouring row is then read to check that the burst stayed in its row. Refresh cycles are run through the whole row range. This checks the counter order, the wrap to row 0 and the moment `all_fresh` is set, and a later read confirms that refresh left the stored data intact.

// File: rtl/mxa_dram_pkg.sv
package mxa_dram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_READ,
    ACC_WRITE,
    ACC_REFRESH
  } acc_kind_e;

  // Row that follows cur in refresh order, wrapping after the last row.
  function automatic int unsigned next_row(int unsigned cur, int unsigned rows);
    return (cur + 1 >= rows) ? 0 : cur + 1;
  endfunction

  // Flat bit position of a cell: row in the upper bits, column in the lower.
  function automatic int unsigned cell_index(int unsigned row, int unsigned col,
                                             int unsigned col_w);
    return (row << col_w) | col;
  endfunction

endpackage

// File: rtl/mxa_dram_edge.sv
module mxa_dram_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic prev_n,
  output logic fall,
  output logic rise
);
  always_ff @(posedge clk) begin
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= sig_n;
  end

  assign fall = prev_n & ~sig_n;
  assign rise = ~prev_n & sig_n;
endmodule

// File: rtl/mxa_dram_array.sv
module mxa_dram_array #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] col,
  input  logic              wr_bit,
  output logic              rd_bit
);
  import mxa_dram_pkg::*;

  localparam int IDX_W = 2 * ADDR_W;
  localparam int CELLS = 1 << IDX_W;

  logic [CELLS-1:0] cells;
  logic [IDX_W-1:0] idx;

  assign idx    = IDX_W'(cell_index(32'(row), 32'(col), ADDR_W));
  assign rd_bit = cells[idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     cells      <= '0;
    else if (wr_en) cells[idx] <= wr_bit;
  end
endmodule

// File: rtl/mxa_dram_rfsh.sv
module mxa_dram_rfsh #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] cnt,
  output logic              all_fresh
);
  import mxa_dram_pkg::*;

  localparam int unsigned ROWS = 1 << ADDR_W;

  logic [ROWS-1:0] flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      flags <= '0;
    end else if (step) begin
      flags[cnt] <= 1'b1;
      cnt        <= ADDR_W'(next_row(32'(cnt), ROWS));
    end
  end

  assign all_fresh = &flags;
endmodule

// File: rtl/mxa_dram.sv
module mxa_dram #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              all_fresh
);
  import mxa_dram_pkg::*;

  // Strobe edge events, named for the checker.
  logic ras_prev_n, ras_fall, ras_rise;
  logic cas_prev_n, cas_fall, cas_rise;
  logic cbr_hit, row_fall;
  logic row_open;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] rfsh_cnt;
  logic rd_active, dout_q, rd_bit;
  acc_kind_e kind;

  mxa_dram_edge u_ras_edge (
    .clk(clk), .rst_n(rst_n), .sig_n(ras_n),
    .prev_n(ras_prev_n), .fall(ras_fall), .rise(ras_rise)
  );

  mxa_dram_edge u_cas_edge (
    .clk(clk), .rst_n(rst_n), .sig_n(cas_n),
    .prev_n(cas_prev_n), .fall(cas_fall), .rise(cas_rise)
  );

  // Column strobe held low across the row strobe edge means refresh.
  assign cbr_hit  = ras_fall & ~cas_prev_n & ~cas_n;
  assign row_fall = ras_fall & ~cbr_hit;

  always_comb begin
    kind = ACC_IDLE;
    if (cbr_hit)                 kind = ACC_REFRESH;
    else if (cas_fall && row_open) kind = we_n ? ACC_READ : ACC_WRITE;
  end

  mxa_dram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(kind == ACC_WRITE),
    .row(row_q), .col(addr),
    .wr_bit(din), .rd_bit(rd_bit)
  );

  mxa_dram_rfsh #(.ADDR_W(ADDR_W)) u_rfsh (
    .clk(clk), .rst_n(rst_n),
    .step(kind == ACC_REFRESH),
    .cnt(rfsh_cnt), .all_fresh(all_fresh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open  <= 1'b0;
      row_q     <= '0;
      rd_active <= 1'b0;
      dout_q    <= 1'b0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
    end else begin
      if (ras_rise) begin
        row_open <= 1'b0;
      end else if (row_fall) begin
        row_open <= 1'b1;
        row_q    <= addr;
      end

      if (kind == ACC_READ) begin
        rd_active <= 1'b1;
        dout_q    <= rd_bit;
      end else if (cas_rise || ras_rise || kind == ACC_WRITE) begin
        rd_active <= 1'b0;
      end

      rfsh_stb <= cbr_hit;
      if (cbr_hit) rfsh_row <= rfsh_cnt;
    end
  end

  assign dout_en = rd_active;
  assign dout    = rd_active & dout_q;
endmodule

// File: rtl/mxa_dram_chk.sv
module mxa_dram_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_rise,
  input logic              cas_fall,
  input logic              cas_rise,
  input logic              row_open,
  input logic              cbr_hit,
  input logic              we_n,
  input logic              dout_en,
  input logic              rfsh_stb,
  input logic [ADDR_W-1:0] rfsh_row,
  input logic [ADDR_W-1:0] rfsh_cnt,
  input logic              all_fresh
);
  import mxa_dram_pkg::*;

  localparam int unsigned ROWS = 1 << ADDR_W;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && row_open && we_n) |=> dout_en); // R3

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && row_open && !we_n) |=> !dout_en); // R11

  AST_CAS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cas_rise |=> !dout_en); // R4

  AST_CBR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_hit |=> (rfsh_stb && rfsh_row == $past(rfsh_cnt))); // R6

  AST_CBR_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_hit |=> !row_open); // R6

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_hit |=> rfsh_cnt == ADDR_W'(next_row(32'($past(rfsh_cnt)), ROWS))); // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cbr_hit |=> $stable(rfsh_cnt)); // R7

  AST_FRESH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    all_fresh |=> all_fresh); // R8

  AST_RAS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise |=> !row_open); // R9
endmodule

bind mxa_dram mxa_dram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mxa_dram_tb.sv
`timescale 1ns/1ps
module mxa_dram_tb;
  localparam int AW   = 5;
  localparam int ROWS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic dout, dout_en, rfsh_stb, all_fresh;
  logic [AW-1:0] rfsh_row;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mxa_dram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en),
    .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .all_fresh(all_fresh)
  );

  // {row, column, data}; swapped row/column pairs carry opposite data.
  localparam logic [2*AW:0] VEC [8] = '{
    {5'd0,  5'd0,  1'b1}, {5'd31, 5'd31, 1'b1},
    {5'd3,  5'd28, 1'b0}, {5'd28, 5'd3,  1'b1},
    {5'd17, 5'd9,  1'b0}, {5'd9,  5'd17, 1'b1},
    {5'd12, 5'd12, 1'b1}, {5'd21, 5'd21, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_row(int r);
    addr = AW'(r); ras_n = 1'b0; cyc(1);
    addr = ~addr;
  endtask

  task automatic close_row();
    ras_n = 1'b1; cyc(1);
  endtask

  task automatic col_write(int c, bit d);
    addr = AW'(c); we_n = 1'b0; din = d; cas_n = 1'b0; cyc(1);
    chk("R11 no drive on write", int'(dout_en), 0);
    addr = ~addr; din = ~d;
    cas_n = 1'b1; we_n = 1'b1; cyc(1);
  endtask

  task automatic col_read(int c, bit exp, string req);
    addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; cyc(1);
    addr = ~addr;
    chk({req, " dout_en"}, int'(dout_en), 1);
    chk({req, " dout"}, int'(dout), int'(exp));
    cyc(1);
    chk("R3 held while CAS low", int'(dout), int'(exp));
    cas_n = 1'b1; cyc(1);
    chk("R4 dout_en after CAS high", int'(dout_en), 0);
    chk("R4 dout after CAS high", int'(dout), 0);
  endtask

  task automatic cbr(int exp_row, string req);
    cas_n = 1'b0; cyc(1);
    ras_n = 1'b0; cyc(1);
    chk({req, " strobe"}, int'(rfsh_stb), 1);
    chk({req, " row"}, int'(rfsh_row), exp_row);
    chk("R6 no drive in refresh", int'(dout_en), 0);
    ras_n = 1'b1; cas_n = 1'b1; cyc(1);
    chk("R6 strobe one cycle", int'(rfsh_stb), 0);
  endtask

  initial begin
    cyc(3);
    chk("R10 reset dout_en", int'(dout_en), 0);
    chk("R10 reset dout", int'(dout), 0);
    chk("R10 reset rfsh_stb", int'(rfsh_stb), 0);
    chk("R10 reset all_fresh", int'(all_fresh), 0);
    rst_n = 1'b1; cyc(2);

    // R1 R2: one row cycle per table entry, then read back
    for (int i = 0; i < 8; i++) begin
      open_row(int'(VEC[i][2*AW:AW+1]));
      col_write(int'(VEC[i][AW:1]), VEC[i][0]);
      close_row();
    end
    for (int i = 0; i < 8; i++) begin
      open_row(int'(VEC[i][2*AW:AW+1]));
      col_read(int'(VEC[i][AW:1]), VEC[i][0], "R1 table readback");
      close_row();
    end

    // R2 overwrite, R3 non-destructive read
    open_row(12); col_write(12, 1'b0); close_row();
    open_row(12); col_read(12, 1'b0, "R2 overwrite"); close_row();
    open_row(28); col_read(3, 1'b1, "R3 first read"); close_row();
    open_row(28); col_read(3, 1'b1, "R3 second read"); close_row();

    // R5 page mode burst
    open_row(7);
    col_write(0, 1'b1); col_write(1, 1'b0); col_write(2, 1'b1); col_write(3, 1'b1);
    close_row();
    open_row(7);
    col_read(0, 1'b1, "R5 page c0"); col_read(1, 1'b0, "R5 page c1");
    col_read(2, 1'b1, "R5 page c2"); col_read(3, 1'b1, "R5 page c3");
    close_row();
    open_row(8); col_read(0, 1'b0, "R5 other row untouched"); close_row();

    // R9: CAS pulse with RAS high writes nothing and drives nothing
    addr = 5'd4; we_n = 1'b0; din = 1'b1; cas_n = 1'b0; cyc(1);
    chk("R9 no drive without row", int'(dout_en), 0);
    chk("R9 no refresh without RAS", int'(rfsh_stb), 0);
    cas_n = 1'b1; we_n = 1'b1; cyc(1);
    open_row(4); col_read(4, 1'b0, "R9 closed row no write"); close_row();

    // R6 R7 R8 refresh sequence through all rows and wrap
    for (int r = 0; r < ROWS; r++) begin
      chk("R8 all_fresh before full pass", int'(all_fresh), 0);
      cbr(r, "R7 refresh order");
    end
    chk("R8 all_fresh after full pass", int'(all_fresh), 1);
    cbr(0, "R7 wrap to row 0");
    chk("R8 all_fresh sticky", int'(all_fresh), 1);
    open_row(0); col_read(0, 1'b1, "R6 data kept through refresh"); close_row();
    open_row(31); col_read(31, 1'b1, "R6 data kept through refresh"); close_row();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule